// File: doc/BRIEF.md
# Gated Clock Frequency Meter

This block counts rising edges of one selected internal clock during a gate window of programmable length, so software can estimate that clock's frequency. Up to 128 clock inputs feed the block, and a 7-bit field picks one of them. The gate length is counted in microsecond ticks. A prescaler divides the system clock by `TICK_DIV` to make each tick. Software programs a length of D microseconds by writing D-1.

Software uses a small register bank on a plain bus with separate read and write addresses. The control word lives at byte offset 0x4 and the read-only edge count at offset 0xC. Offset 0x0 always reads zero. Each selected clock drives its own toggle flip-flop. That toggle crosses into the system domain through a two-flop synchroniser, and each change of the toggle counts as one rising edge. The measured clock must therefore be slower than half the system clock. The count saturates at all ones, and software treats that value as an overflowed, invalid result. The block runs one gate per start in one-shot mode, or one gate after another in continuous mode. It can raise a one-cycle interrupt pulse at the end of every gate.

Top module: `freq_meter`

## Requirements
- R1: After reset, the control word (0x4), the result (0xC) and offset 0x0 all read zero, and `irq` is low.
- R2: With control bits 15:0 set to D-1, the gate lasts exactly D×`TICK_DIV` system cycles. Busy (control bit 31) reads 1 from the cycle after the start write and drops D×`TICK_DIV` cycles after that write.
- R3: At the end of a gate, the result register bits `CNT_W`-1:0 hold the number of rising edges of the selected clock seen during the gate, within ±1. The upper bits read zero.
- R4: Control bits 26:20 choose which of the `NUM_SRC` clock inputs is measured. Only that input affects the count.
- R5: The count saturates at all ones (0xFFFF when `CNT_W`=16) and never wraps.
- R6: With control bit 17 clear (one-shot), busy clears after a single gate, and no further result or interrupt follows.
- R7: With control bit 17 set (continuous), a new gate starts by itself at the end of each gate. The result register is refreshed at every gate end.
- R8: With control bit 18 set, `irq` pulses high for exactly one cycle at each gate end, in the same cycle the new result becomes readable. With bit 18 clear, `irq` stays low.
- R9: A write to 0x4 with bit 16 (enable) and bit 19 (start) both set begins a new gate. Bit 19 does not stay stored and always reads 0.
- R10: A write to 0x4 with bit 16 clear stops any gate at once and clears busy. If that write lands in a gate's final cycle, the result keeps its old value and no interrupt is raised.
- R11: Writes to the result offset 0xC have no effect on the result or the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_clks | input | NUM_SRC | Clock inputs that can be measured |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_waddr | input | 4 | Byte offset of the write |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 4 | Byte offset of the read |
| bus_rdata | output | 32 | Read data, combinational from `bus_raddr` |
| irq | output | 1 | One-cycle pulse at each gate end when interrupts are enabled |

## Verification
A gate's final cycle and a control write that clears the enable can fall on the same clock edge. In that case the abort wins: the gate's result and its interrupt are both dropped. The bench counts exactly D×`TICK_DIV` cycles from the start write and places the abort write on that edge. It then checks at the ports that busy is low, `irq` never rose, and the result still holds the value read before the gate. A control run with the same timing but no abort confirms that this edge really is the gate's final one: busy falls and the interrupt pulses there.

// File: rtl/fm_pkg.sv
package fm_pkg;

    localparam int DUR_W   = 16;
    localparam int SRC_W   = 7;

    localparam int BIT_EN   = 16;
    localparam int BIT_CONT = 17;
    localparam int BIT_IE   = 18;
    localparam int BIT_RUN  = 19;
    localparam int SRC_LSB  = 20;
    localparam int BIT_BUSY = 31;

    localparam logic [3:0] OFS_DUTY = 4'h0;
    localparam logic [3:0] OFS_CTRL = 4'h4;
    localparam logic [3:0] OFS_RES  = 4'hC;

    typedef struct packed {
        logic [DUR_W-1:0] dur;
        logic [SRC_W-1:0] src;
        logic             ie;
        logic             cont;
        logic             en;
    } ctrl_t;

endpackage

// File: rtl/fm_edge_sync.sv
module fm_edge_sync
    import fm_pkg::*;
#(
    parameter int NUM_SRC = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_clks,
    input  logic [SRC_W-1:0]   sel,
    output logic               edge_p
);

    logic [NUM_SRC-1:0] tog;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_tog
        logic t_q;
        always_ff @(posedge src_clks[g] or negedge rst_n) begin
            if (!rst_n) t_q <= 1'b0;
            else        t_q <= ~t_q;
        end
        assign tog[g] = t_q;
    end

    logic sel_tog;
    always_comb begin
        sel_tog = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SRC_W'(i)) sel_tog = tog[i];
        end
    end

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = sel_tog;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign edge_p = sy_q.s2 ^ sy_q.s3;

endmodule

// File: rtl/fm_gate_timer.sv
module fm_gate_timer
    import fm_pkg::*;
#(
    parameter int TICK_DIV = 125
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [DUR_W-1:0] dur,
    output logic             gate_end
);

    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DUR_W-1:0] tk;
    } tmr_t;

    tmr_t tm_d, tm_q;
    logic tick;

    assign tick     = run && (tm_q.pre == PRE_LAST);
    assign gate_end = tick && (tm_q.tk == dur);

    always_comb begin
        tm_d = tm_q;
        if (start || !run || gate_end) begin
            tm_d = '0;
        end else if (tick) begin
            tm_d.pre = '0;
            tm_d.tk  = tm_q.tk + DUR_W'(1);
        end else begin
            tm_d.pre = tm_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

endmodule

// File: rtl/fm_sat_counter.sv
module fm_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_plus
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_plus = cnt_q;
        if (inc && (cnt_q != CNT_MAX)) cnt_plus = cnt_q + CNT_W'(1);
        cnt_d = clear ? '0 : cnt_plus;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/freq_meter.sv
module freq_meter
    import fm_pkg::*;
#(
    parameter int NUM_SRC  = 128,
    parameter int TICK_DIV = 125,
    parameter int CNT_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_clks,
    input  logic               bus_wr,
    input  logic [3:0]         bus_waddr,
    input  logic [31:0]        bus_wdata,
    input  logic [3:0]         bus_raddr,
    output logic [31:0]        bus_rdata,
    output logic               irq
);

    localparam int RES_PAD = 32 - CNT_W;

    typedef struct packed {
        ctrl_t            ctrl;
        logic             busy;
        logic [CNT_W-1:0] result;
        logic             irq;
    } state_t;

    state_t st_d, st_q;

    logic             edge_p;
    logic             gate_end;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_plus;
    logic             wr_ctrl;
    logic             start;
    logic             cnt_clear;
    ctrl_t            ctrl_new;
    logic             unused_wbits;

    assign unused_wbits = ^bus_wdata[31:27];

    always_comb begin
        ctrl_new.dur  = bus_wdata[DUR_W-1:0];
        ctrl_new.en   = bus_wdata[BIT_EN];
        ctrl_new.cont = bus_wdata[BIT_CONT];
        ctrl_new.ie   = bus_wdata[BIT_IE];
        ctrl_new.src  = bus_wdata[SRC_LSB +: SRC_W];
    end

    assign wr_ctrl   = bus_wr && (bus_waddr == OFS_CTRL);
    assign start     = wr_ctrl && bus_wdata[BIT_EN] && bus_wdata[BIT_RUN];
    assign cnt_clear = start || gate_end || !st_q.busy;

    fm_edge_sync #(.NUM_SRC(NUM_SRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_clks (src_clks),
        .sel      (st_q.ctrl.src),
        .edge_p   (edge_p)
    );

    fm_gate_timer #(.TICK_DIV(TICK_DIV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .run      (st_q.busy),
        .dur      (st_q.ctrl.dur),
        .gate_end (gate_end)
    );

    fm_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .inc      (edge_p && st_q.busy),
        .cnt      (cnt),
        .cnt_plus (cnt_plus)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;

        if (gate_end) begin
            st_d.result = cnt_plus;
            st_d.irq    = st_q.ctrl.ie;
            st_d.busy   = st_q.ctrl.cont;
        end

        if (wr_ctrl) begin
            st_d.ctrl = ctrl_new;
            if (!ctrl_new.en) begin
                st_d.busy   = 1'b0;
                st_d.result = st_q.result;
                st_d.irq    = 1'b0;
            end else if (start) begin
                st_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_raddr)
            OFS_CTRL: begin
                bus_rdata[DUR_W-1:0]           = st_q.ctrl.dur;
                bus_rdata[BIT_EN]              = st_q.ctrl.en;
                bus_rdata[BIT_CONT]            = st_q.ctrl.cont;
                bus_rdata[BIT_IE]              = st_q.ctrl.ie;
                bus_rdata[SRC_LSB +: SRC_W]    = st_q.ctrl.src;
                bus_rdata[BIT_BUSY]            = st_q.busy;
            end
            OFS_RES:  bus_rdata = {{RES_PAD{1'b0}}, st_q.result};
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = st_q.irq;

    logic busy_s, en_s, ie_s;
    logic [CNT_W-1:0] result_s;
    assign busy_s   = st_q.busy;
    assign en_s     = st_q.ctrl.en;
    assign ie_s     = st_q.ctrl.ie;
    assign result_s = st_q.result;

endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             en,
    input logic             ie,
    input logic             irq,
    input logic             gate_end,
    input logic             bus_wr,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] result
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    a_r10_busy_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> en);

    a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r8_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ie));

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt == CNT_MAX && !gate_end && !bus_wr) |=> (cnt == CNT_MAX));

    a_r3_result_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $past(gate_end));

    a_r2_busy_falls_on_end_or_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(gate_end || bus_wr));

endmodule

bind freq_meter fm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy_s),
    .en       (en_s),
    .ie       (ie_s),
    .irq      (irq),
    .gate_end (gate_end),
    .bus_wr   (bus_wr),
    .cnt      (cnt),
    .result   (result_s)
);

// File: tb/freq_meter_bench.sv
`timescale 1ns/1ps
module freq_meter_bench;

    localparam int NSRC = 128;
    localparam int TD   = 5;
    localparam int CW   = 8;
    localparam logic [3:0] A_DUTY = 4'h0;
    localparam logic [3:0] A_CTRL = 4'h4;
    localparam logic [3:0] A_RES  = 4'hC;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] mclk = '0;
    logic            bus_wr = 1'b0;
    logic [3:0]      bus_waddr = 4'h0;
    logic [31:0]     bus_wdata = '0;
    logic [3:0]      bus_raddr = A_RES;
    logic [31:0]     bus_rdata;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    exp;
        int    tol;
        string req;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    initial begin #1; forever #16 mclk[3]   = ~mclk[3];   end
    initial begin #1; forever #24 mclk[100] = ~mclk[100]; end
    initial begin #1; forever #12 mclk[5]   = ~mclk[5];   end
    initial begin #1; forever #20 mclk[7]   = ~mclk[7];   end

    freq_meter #(.NUM_SRC(NSRC), .TICK_DIV(TD), .CNT_W(CW)) u_freq_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_clks  (mclk),
        .bus_wr    (bus_wr),
        .bus_waddr (bus_waddr),
        .bus_wdata (bus_wdata),
        .bus_raddr (bus_raddr),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int dur, input int src, input bit en,
                                       input bit run, input bit cont, input bit ie);
        logic [31:0] w;
        w = '0;
        w[15:0]  = 16'(dur);
        w[16]    = en;
        w[17]    = cont;
        w[18]    = ie;
        w[19]    = run;
        w[26:20] = 7'(src);
        return w;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_waddr = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_raddr = a;
        #1;
        d = bus_rdata;
        bus_raddr = A_RES;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int n;
        n = 0;
        rd(A_CTRL, v);
        while (v[31] && n < 5000) begin
            @(negedge clk);
            rd(A_CTRL, v);
            n++;
        end
        chk(!v[31], req, int'(v[31]), 0);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // scoreboard monitor: one expected item per interrupt pulse (R3, R8)
    always @(posedge clk) begin
        #2;
        if (rst_n && irq) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R8 unexpected irq", 1, 0);
            end else begin
                item_t it;
                int act;
                int diff;
                it   = sb.pop_front();
                act  = int'(bus_rdata);
                diff = act - it.exp;
                if (diff < 0) diff = -diff;
                chk(diff <= it.tol, it.req, act, it.exp);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] r0;
        int n;
        int nn;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(A_CTRL, v); chk(v == 0, "R1 ctrl", int'(v), 0);
        rd(A_RES, v);  chk(v == 0, "R1 result", int'(v), 0);
        rd(A_DUTY, v); chk(v == 0, "R1 offset 0x0", int'(v), 0);
        chk(irq == 1'b0, "R1 irq", int'(irq), 0);

        // R3/R9 one-shot on source 3 (4-cycle period), D=20 -> 100 cycles -> 25 edges
        sb.push_back('{25, 1, "R3 one-shot count"});
        wr(A_CTRL, mk(19, 3, 1, 1, 0, 1));
        rd(A_CTRL, v);
        chk(v[31] == 1'b1, "R9 busy after start", int'(v[31]), 1);
        chk(v[19] == 1'b0, "R9 start bit reads 0", int'(v[19]), 0);
        chk(v[26:20] == 7'd3, "R4 source readback", int'(v[26:20]), 3);
        wait_idle("R6 busy clears");
        repeat (200) @(negedge clk);
        rd(A_CTRL, v);
        chk(v[31] == 1'b0, "R6 one-shot stays idle", int'(v[31]), 0);

        // R4 source 100 (6-cycle period), D=36 -> 180 cycles -> 30 edges
        sb.push_back('{30, 1, "R4 source select count"});
        wr(A_CTRL, mk(35, 100, 1, 1, 0, 1));
        wait_idle("R4 busy clears");

        // R8 interrupt disabled: no pulse, result still valid
        wr(A_CTRL, mk(19, 3, 1, 1, 0, 0));
        wait_idle("R8 busy clears");
        rd(A_RES, v);
        chk(v >= 24 && v <= 26, "R8 result without irq", int'(v), 25);

        // R11 write to result ignored
        rd(A_RES, r0);
        wr(A_RES, 32'hFFFF_FFFF);
        rd(A_RES, v);
        chk(v == r0, "R11 result unchanged", int'(v), int'(r0));
        rd(A_CTRL, v);
        chk(v == mk(19, 3, 1, 0, 0, 0), "R11 ctrl unchanged", int'(v), int'(mk(19, 3, 1, 0, 0, 0)));

        // R5 saturation: source 5 (3-cycle period), D=200 -> 333 edges -> 255
        sb.push_back('{255, 0, "R5 saturated count"});
        wr(A_CTRL, mk(199, 5, 1, 1, 0, 1));
        wait_idle("R5 busy clears");

        // R7 continuous: source 7 (5-cycle period), D=10 -> 10 edges per gate
        for (int k = 0; k < 3; k++) sb.push_back('{10, 1, "R7 continuous count"});
        wr(A_CTRL, mk(9, 7, 1, 1, 1, 1));
        n = 0;
        while (sb.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(sb.size() == 0, "R7 three gates seen", sb.size(), 0);
        wr(A_CTRL, mk(9, 7, 0, 0, 1, 1));
        rd(A_CTRL, v);
        chk(v[31] == 1'b0, "R10 abort clears busy", int'(v[31]), 0);
        repeat (200) @(negedge clk);

        // R2 exact gate length: D=7 -> 35 cycles, source 0 idle
        nn = 7 * TD;
        sb.push_back('{0, 1, "R2 idle source count"});
        wr(A_CTRL, mk(6, 0, 1, 1, 0, 1));
        repeat (nn - 1) @(negedge clk);
        rd(A_CTRL, v);
        chk(v[31] == 1'b1, "R2 busy in last gate cycle", int'(v[31]), 1);
        @(negedge clk);
        rd(A_CTRL, v);
        chk(v[31] == 1'b0, "R2 busy low after gate", int'(v[31]), 0);
        chk(irq == 1'b1, "R8 irq at gate end", int'(irq), 1);
        @(negedge clk);
        chk(irq == 1'b0, "R8 irq one cycle", int'(irq), 0);

        // R10 abort in the gate's final cycle on source 3
        repeat (10) @(negedge clk);
        rd(A_RES, r0);
        wr(A_CTRL, mk(6, 3, 1, 1, 0, 1));
        repeat (nn - 1) @(negedge clk);
        wr(A_CTRL, mk(6, 3, 0, 0, 0, 1));
        rd(A_CTRL, v);
        chk(v[31] == 1'b0, "R10 busy after same-cycle abort", int'(v[31]), 0);
        chk(irq == 1'b0, "R10 no irq on same-cycle abort", int'(irq), 0);
        rd(A_RES, v);
        chk(v == r0, "R10 result kept on same-cycle abort", int'(v), int'(r0));

        // R10 abort in mid gate
        wr(A_CTRL, mk(99, 3, 1, 1, 0, 1));
        repeat (100) @(negedge clk);
        wr(A_CTRL, mk(99, 3, 0, 0, 0, 1));
        repeat (600) @(negedge clk);
        rd(A_RES, v);
        chk(v == r0, "R10 result kept on mid-gate abort", int'(v), int'(r0));

        chk(sb.size() == 0, "R8 scoreboard drained", sb.size(), 0);
        done = 1'b1;
        summary();
    end

endmodule